// File: doc/BRIEF.md
# Dual-Period Service Watchdog

This block watches a processor's service line and flags a processor that has stopped running its code. The processor keeps the watchdog quiet by toggling the service line. A rising edge and a falling edge both count. If no edge arrives within the current period, the block does two things. It sends a one-cycle expiry strobe to the system reset generator. It also pulls its active-low watchdog status output low, and that output stays low until the next edge on the service line.

The service line is given as two inputs: a value bit, and a flag that marks the line as undriven (floating). The pin-level detection of the third level is not part of this block. A floating line disables the watchdog. So does a low-supply flag or a battery-backup flag, which also force the status output high.

All counting advances on a prescaled tick input, one step per tick. After every reset the watchdog uses a long grace period. It moves to the shorter normal period at the first service edge after reset is released. The two period lengths depend on the clock-source select (internal oscillator or external clock) and on a period-select input.

Top module: `svc_watchdog`

## Requirements
- R1: A service edge in either direction (0 to 1 or 1 to 0) restarts the count. After an edge is sampled, the next expiry comes a full period later.
- R2: While the floating flag is 1, the watchdog never expires and the counter is held cleared. Value changes seen while the line is floating, or in the first cycle after it stops floating, are not treated as service edges. In particular they do not raise the status output.
- R3: While the supply-low flag or the battery-mode flag is 1, the watchdog never expires. The active-low status output is 1 from the next clock edge onward.
- R4: While reset-active is 1, the counter is held cleared and the long period is selected. Counting begins on the first tick after reset-active returns to 0. The long period is also selected again after either power flag has been set.
- R5: The short period replaces the long period only after a service edge that arrives while reset-active and both power flags are 0.
- R6: When the clock-source select is 1 (external clock), the long period is LONG_EXT (4096) ticks and the short period is SHORT_EXT (1024) ticks. The period-select input has no effect in this mode.
- R7: When the clock-source select is 0 (internal oscillator), the long period is LONG_INT (16384) ticks. The short period is SHORT_INT (1024) ticks when the period-select input is 0, and LONG_INT ticks when it is 1.
- R8: The active-low status output goes to 0 on the same clock edge on which the expiry strobe is raised. It stays 0 until a service edge is sampled or a power flag becomes 1.
- R9: The expiry strobe is exactly one cycle wide. If the line is never serviced and reset-active stays 0, expiries recur once per current period.
- R10: The counter advances only in cycles where the tick input is 1. With the tick at 0 the count holds.
- R11: After the design reset, the expiry strobe is 0 and the active-low status output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low design reset |
| tick_i | input | 1 | Prescaled count enable; one period step per high cycle |
| svc_val_i | input | 1 | Value of the service line |
| svc_float_i | input | 1 | 1 when the service line is undriven (watchdog disabled) |
| ext_clk_sel_i | input | 1 | 1 selects external-clock period lengths, 0 internal-oscillator ones |
| per_sel_i | input | 1 | Internal mode only: 0 gives a short normal period, 1 a long one |
| rst_active_i | input | 1 | 1 while the system reset generator holds reset |
| supply_low_i | input | 1 | 1 while the supply is below threshold |
| batt_mode_i | input | 1 | 1 while the system runs on backup power |
| timeout_o | output | 1 | One-cycle expiry strobe to the reset generator |
| wdo_n_o | output | 1 | Sticky active-low watchdog status |

## Verification
The assertions assume that the clock-source select and period-select inputs change only while reset-active is 1. They also assume the tick is a plain per-cycle enable and that the design reset is applied before any stimulus. Without the first assumption, a count in progress would be compared against a limit that changed partway through the period. The bench meets these assumptions as follows. It changes the mode inputs only inside its reset-pulse task. It drives every input on the falling clock edge. It lets the reset generator's role be played by the stimulus, which raises reset-active only between periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  typedef enum logic {
    PH_SHORT = 1'b0,
    PH_LONG  = 1'b1
  } phase_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/svc_edge_det.sv
module svc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic val_i,
  input  logic float_i,
  output logic edge_o
);

  logic val_q;
  logic flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= 1'b0;
      flt_q <= 1'b1;
    end else begin
      val_q <= val_i;
      flt_q <= float_i;
    end
  end

  // Edge only when both the current and the previous sample were driven.
  assign edge_o = (val_i ^ val_q) & ~float_i & ~flt_q;

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned LONG_EXT  = 4096,
  parameter int unsigned SHORT_EXT = 1024,
  parameter int unsigned LONG_INT  = 16384,
  parameter int unsigned SHORT_INT = 1024,
  parameter int unsigned CNT_W     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_active_i,
  input  logic             pwr_off_i,
  input  logic             edge_i,
  input  logic             ext_clk_sel_i,
  input  logic             per_sel_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             long_phase_o
);

  localparam logic [CNT_W-1:0] L_EXT = CNT_W'(LONG_EXT);
  localparam logic [CNT_W-1:0] S_EXT = CNT_W'(SHORT_EXT);
  localparam logic [CNT_W-1:0] L_INT = CNT_W'(LONG_INT);
  localparam logic [CNT_W-1:0] S_INT = CNT_W'(SHORT_INT);

  phase_e   phase_q;
  clk_src_e src;

  assign src = clk_src_e'(ext_clk_sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LONG;
    end else if (rst_active_i || pwr_off_i) begin
      phase_q <= PH_LONG;
    end else if (edge_i) begin
      phase_q <= PH_SHORT;
    end
  end

  always_comb begin
    unique case (src)
      SRC_EXTERNAL: limit_o = (phase_q == PH_LONG) ? L_EXT : S_EXT;
      default: begin
        if (phase_q == PH_LONG) limit_o = L_INT;
        else                    limit_o = per_sel_i ? L_INT : S_INT;
      end
    endcase
  end

  assign long_phase_o = (phase_q == PH_LONG);

  AST_LONG_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_active_i || pwr_off_i) |=> long_phase_o); // R4

  AST_SHORT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && !rst_active_i && !pwr_off_i) |=> !long_phase_o); // R5

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_i && !rst_active_i && !pwr_off_i) |=> $stable(long_phase_o)); // R5

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o,
  output logic             strobe_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             strobe_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = limit_i - CNT_W'(1);
  assign expire_o = en_i & ~clr_i & tick_i & (cnt_q >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= expire_o;
      if (clr_i || expire_o) cnt_q <= '0;
      else if (en_i && tick_i) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign strobe_o = strobe_q;

  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tick_i) |=> $stable(cnt_q)); // R10

  AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R4

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o); // R9

  AST_NO_EXPIRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !strobe_o); // R2

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned LONG_EXT  = 4096,
  parameter int unsigned SHORT_EXT = 1024,
  parameter int unsigned LONG_INT  = 16384,
  parameter int unsigned SHORT_INT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic svc_val_i,
  input  logic svc_float_i,
  input  logic ext_clk_sel_i,
  input  logic per_sel_i,
  input  logic rst_active_i,
  input  logic supply_low_i,
  input  logic batt_mode_i,
  output logic timeout_o,
  output logic wdo_n_o
);

  localparam int unsigned MAX_PER = max4(LONG_EXT, SHORT_EXT, LONG_INT, SHORT_INT);
  localparam int unsigned CNT_W   = $clog2(MAX_PER + 1);

  logic             svc_edge;
  logic             pwr_off;
  logic             cnt_en;
  logic             cnt_clr;
  logic [CNT_W-1:0] limit;
  logic             long_phase;
  logic             expire;
  logic             wdo_n_q;

  assign pwr_off = supply_low_i | batt_mode_i;
  assign cnt_en  = ~svc_float_i & ~pwr_off & ~rst_active_i;
  assign cnt_clr = svc_edge | ~cnt_en;

  svc_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .val_i   (svc_val_i),
    .float_i (svc_float_i),
    .edge_o  (svc_edge)
  );

  wdt_period_sel #(
    .LONG_EXT  (LONG_EXT),
    .SHORT_EXT (SHORT_EXT),
    .LONG_INT  (LONG_INT),
    .SHORT_INT (SHORT_INT),
    .CNT_W     (CNT_W)
  ) u_sel (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_active_i  (rst_active_i),
    .pwr_off_i     (pwr_off),
    .edge_i        (svc_edge),
    .ext_clk_sel_i (ext_clk_sel_i),
    .per_sel_i     (per_sel_i),
    .limit_o       (limit),
    .long_phase_o  (long_phase)
  );

  wdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (cnt_en),
    .clr_i    (cnt_clr),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .expire_o (expire),
    .strobe_o (timeout_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdo_n_q <= 1'b1;
    else if (pwr_off)  wdo_n_q <= 1'b1;
    else if (svc_edge) wdo_n_q <= 1'b1;
    else if (expire)   wdo_n_q <= 1'b0;
  end

  assign wdo_n_o = wdo_n_q;

  AST_PWR_WDO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |=> (wdo_n_o && !timeout_o)); // R3

  AST_WDO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdo_n_o && !svc_edge && !pwr_off) |=> !wdo_n_o); // R8

  AST_TIMEOUT_WDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !wdo_n_o); // R8

  AST_FLOAT_WDO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_float_i && !pwr_off) |=> $stable(wdo_n_o)); // R2

  AST_RST_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active_i |=> (!timeout_o && long_phase)); // R4

endmodule

// File: tb/tb_svc_watchdog.sv
module tb_svc_watchdog;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b1;
  logic svc_val_i = 1'b0;
  logic svc_float_i = 1'b0;
  logic ext_clk_sel_i = 1'b0;
  logic per_sel_i = 1'b0;
  logic rst_active_i = 1'b1;
  logic supply_low_i = 1'b0;
  logic batt_mode_i = 1'b0;
  logic timeout_o;
  logic wdo_n_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  svc_watchdog dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .svc_val_i     (svc_val_i),
    .svc_float_i   (svc_float_i),
    .ext_clk_sel_i (ext_clk_sel_i),
    .per_sel_i     (per_sel_i),
    .rst_active_i  (rst_active_i),
    .supply_low_i  (supply_low_i),
    .batt_mode_i   (batt_mode_i),
    .timeout_o     (timeout_o),
    .wdo_n_o       (wdo_n_o)
  );

  // {ext_clk_sel, per_sel, serviced, expected period}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 15'd4096},   // R6 long
    {1'b1, 1'b0, 1'b1, 15'd1024},   // R6 short, R5
    {1'b0, 1'b0, 1'b0, 15'd16384},  // R7 long, R4
    {1'b0, 1'b0, 1'b1, 15'd1024},   // R7 short sel 0, R5
    {1'b0, 1'b1, 1'b1, 15'd16384},  // R7 short sel 1
    {1'b1, 1'b1, 1'b1, 15'd1024}    // R6 sel ignored
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rst_pulse(input bit ext, input bit per);
    rst_active_i = 1'b1;
    ext_clk_sel_i = ext;
    per_sel_i = per;
    step(3);
    rst_active_i = 1'b0;
  endtask

  task automatic toggle();
    svc_val_i = ~svc_val_i;
  endtask

  // expiry strobe expected exactly after n posedges from now
  task automatic expect_timeout(input int n, input string tag);
    step(n - 1);
    check(timeout_o == 1'b0, {tag, " early"}, timeout_o, 0);
    step(1);
    check(timeout_o == 1'b1, {tag, " strobe"}, timeout_o, 1);
    check(wdo_n_o == 1'b0, {tag, " wdo low (R8)"}, wdo_n_o, 0);
    step(1);
    check(timeout_o == 1'b0, {tag, " one cycle (R9)"}, timeout_o, 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (timeout_o) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    check(timeout_o == 1'b0, "R11 reset timeout", timeout_o, 0);
    check(wdo_n_o == 1'b1, "R11 reset wdo", wdo_n_o, 1);
    rst_n = 1'b1;
    step(2);

    // table-driven period checks
    for (int v = 0; v < NV; v++) begin
      rst_pulse(VEC[v][17], VEC[v][16]);
      if (VEC[v][15]) begin
        step(5);
        toggle();
        expect_timeout(int'(VEC[v][14:0]) + 1, "R5/R6/R7 serviced period");
      end else begin
        expect_timeout(int'(VEC[v][14:0]), "R4/R6/R7 long period");
      end
    end

    // R1: both edge directions restart the count
    rst_pulse(1'b1, 1'b0);
    step(3);
    toggle();
    step(600);
    toggle();
    step(600);
    toggle();
    expect_timeout(1025, "R1 restart");

    // R8 sticky, R9 recurrence
    step(100);
    check(wdo_n_o == 1'b0, "R8 sticky", wdo_n_o, 0);
    expect_timeout(1023 - 100, "R9 recurrence");
    toggle();
    step(1);
    check(wdo_n_o == 1'b1, "R8 released by edge", wdo_n_o, 1);
    expect_timeout(1024, "R8 next expiry");

    // R2: floating disables and ignores edges
    svc_float_i = 1'b1;
    step(2);
    toggle();
    step(3);
    check(wdo_n_o == 1'b0, "R2 edge ignored while floating", wdo_n_o, 0);
    expect_quiet(2000, "R2 no expiry floating");
    toggle();
    svc_float_i = 1'b0;
    step(3);
    check(wdo_n_o == 1'b0, "R2 no edge on unfloat", wdo_n_o, 0);
    expect_timeout(1024 - 3, "R2 count resumes");

    // R3: supply-low and battery mode
    supply_low_i = 1'b1;
    step(1);
    check(wdo_n_o == 1'b1, "R3 supply low forces high", wdo_n_o, 1);
    expect_quiet(5000, "R3 no expiry supply low");
    supply_low_i = 1'b0;
    batt_mode_i = 1'b1;
    expect_quiet(3000, "R3 no expiry battery");
    check(wdo_n_o == 1'b1, "R3 battery wdo high", wdo_n_o, 1);
    batt_mode_i = 1'b0;
    expect_timeout(4096, "R4 long after power loss");

    // R4: counter held during long reset
    rst_active_i = 1'b1;
    expect_quiet(5000, "R4 hold in reset");
    rst_active_i = 1'b0;
    expect_timeout(4096, "R4 long after release");

    // R10: tick gating
    rst_pulse(1'b1, 1'b0);
    tick_i = 1'b0;
    toggle();
    expect_quiet(2000, "R10 no count without tick");
    tick_i = 1'b1;
    expect_timeout(1024, "R10 count with tick");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule